// File: doc/BRIEF.md
# Non-Retriggerable One-Shot Pulse Generator

This block is a clocked monostable pulse generator. It has two trigger inputs of opposite edge polarity and an active-low clear. It drives a pulse of a programmed number of clock cycles on a pair of complementary outputs. One trigger input fires on a falling edge and the other on a rising edge. Each one only counts when the other is at its enabling level, so either input can serve as an inhibit for the other. Releasing the clear can itself start a pulse, provided both trigger inputs are at their enabling levels.

All three control inputs are asynchronous to the clock. Each passes through a two-flop synchronizer before its edges are examined. A pulse that is running cannot be extended or restarted: trigger edges that arrive while it runs are dropped. To build a dual part, instantiate the block twice.

Top module: `one_shot_pulser`

## Requirements
- R1: A falling edge on `fall_trig_in` starts a pulse only if `rise_trig_in` is high at the same synchronized cycle; with `rise_trig_in` low, the edge produces no pulse.
- R2: A rising edge on `rise_trig_in` starts a pulse only if `fall_trig_in` is low at the same synchronized cycle; with `fall_trig_in` high, the edge produces no pulse.
- R3: A low level on `clear_n_in` ends any running pulse. `pulse_out` goes low and `pulse_n_out` goes high at the third rising clock edge after the change. While clear is held low, no edge on either trigger input starts a pulse.
- R4: A rising edge on `clear_n_in`, with `fall_trig_in` low and `rise_trig_in` high, starts a pulse.
- R5: While a pulse is active, trigger edges are ignored and do not lengthen it. This includes an edge whose detection falls on the pulse's final cycle. An edge detected one cycle later starts a new pulse.
- R6: `pulse_n_out` is always the inverse of `pulse_out`; at rest `pulse_out` is low.
- R7: `width_in` is sampled when a trigger is accepted. `pulse_out` then stays high for exactly that many cycles, unaffected by later changes to `width_in`. A value of zero produces no pulse.
- R8: After an input change between clock edges that qualifies as a trigger, `pulse_out` first reads high after the third rising edge.
- R9: Synchronous reset (`rst_n` low) holds `pulse_out` low and the counter at zero. Input levels present during reset are not seen as edges after its release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fall_trig_in | input | 1 | Falling-edge trigger, enables the rising trigger while low |
| rise_trig_in | input | 1 | Rising-edge trigger, enables the falling trigger while high |
| clear_n_in | input | 1 | Active-low clear; its release can fire a pulse |
| width_in | input | CNT_W | Pulse length in clock cycles |
| pulse_out | output | 1 | High while a pulse runs |
| pulse_n_out | output | 1 | Complement of pulse_out |

## Verification
Two collisions matter here. One is between acceptance of a new trigger and the timeout of a running pulse. The bench places a fresh falling edge so that its detection lands on the last high cycle and expects one pulse of the original length. It then moves the edge one cycle later and expects two back-to-back pulses. The other collision is between clear and a running pulse. Clear is dropped mid-pulse, and the high time is expected to be cut to the cycles before clear takes effect. While clear is held, trigger edges must produce nothing, and releasing clear with both triggers at their enabling levels must yield a full pulse.

// File: rtl/one_shot_pkg.sv
// Package: one_shot_pkg
// Shared index constants for the one-shot pulser's synchronized input vector.
// Assumes the three control inputs are packed in the order given below.
package one_shot_pkg;
    localparam int IN_FALL  = 0;   // falling-edge trigger
    localparam int IN_RISE  = 1;   // rising-edge trigger
    localparam int IN_CLEAR = 2;   // active-low clear
    localparam int NUM_IN   = 3;
endpackage

// File: rtl/one_shot_sync.sv
// Module: one_shot_sync
// Multi-bit synchronizer chain with a one-cycle history register per bit.
// Assumes each bit is an independent asynchronous level. During reset every
// stage and the history are loaded from the raw input, so when reset is
// released the history equals the current level and no false edge appears.
module one_shot_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] lvl,
    output logic [N-1:0] prev
);
    localparam int LAST = STAGES - 1;

    logic [N-1:0] chain [STAGES];

    // Stage 0 samples the asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= din;
        else        chain[0] <= din;
    end

    // Later stages shift the sampled value along the chain.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= din;
            else        chain[s] <= chain[s-1];
        end
    end

    // History register holds the synchronized level from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= din;
        else        prev <= chain[LAST];
    end

    assign lvl = chain[LAST];
endmodule

// File: rtl/one_shot_qualify.sv
// Module: one_shot_qualify
// Detects edges on the synchronized inputs and decides whether a trigger is
// accepted. Assumes lvl/prev come from one_shot_sync and busy from the timer.
module one_shot_qualify
    import one_shot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] lvl,
    input  logic [NUM_IN-1:0] prev,
    input  logic              busy,
    output logic              fire
);
    logic fall_edge, rise_edge, clear_release;
    logic enable_fall, enable_rise, enable_clear;

    // Edge detection per input.
    always_comb begin
        fall_edge     = prev[IN_FALL] & ~lvl[IN_FALL];
        rise_edge     = ~prev[IN_RISE] & lvl[IN_RISE];
        clear_release = ~prev[IN_CLEAR] & lvl[IN_CLEAR];
    end

    // Each trigger is enabled by the opposite input's level.
    always_comb begin
        enable_fall  = fall_edge & lvl[IN_RISE];
        enable_rise  = rise_edge & ~lvl[IN_FALL];
        enable_clear = clear_release & ~lvl[IN_FALL] & lvl[IN_RISE];
    end

    // Accept only when idle and not held in clear.
    always_comb begin
        fire = lvl[IN_CLEAR] & ~busy & (enable_fall | enable_rise | enable_clear);
    end

    // R3: held clear blocks every trigger.
    assert_no_fire_in_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl[IN_CLEAR]) |-> !fire);

    // R1/R2/R4: a fire always has some input edge behind it.
    assert_fire_needs_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (lvl != prev));
endmodule

// File: rtl/one_shot_timer.sv
// Module: one_shot_timer
// Down-counter that sets the pulse length. Assumes load is asserted only when
// idle; a held clear empties it regardless of load.
module one_shot_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_lvl,
    input  logic             load,
    input  logic [CNT_W-1:0] width,
    output logic             busy
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt;

    // Counter: reset, clear, load, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= ZERO;
        else if (!clear_lvl)   cnt <= ZERO;
        else if (load)         cnt <= width;
        else if (cnt != ZERO)  cnt <= cnt - ONE;
    end

    // Pulse is active while the counter is nonzero.
    assign busy = (cnt != ZERO);

    // R3: a held clear empties the counter on the next edge.
    assert_clear_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_lvl) |=> (cnt == ZERO));

    // R5: a running count never grows (no retrigger from the qualifier).
    assert_no_extend_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != ZERO) |=> (cnt < $past(cnt)));

    // R7: an accepted trigger captures the width input.
    assert_width_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && clear_lvl) |=> (cnt == $past(width)));
endmodule

// File: rtl/one_shot_pulser.sv
// Module: one_shot_pulser
// Top of the non-retriggerable one-shot: synchronizer, trigger qualifier and
// width timer. Assumes all control inputs are asynchronous levels.
module one_shot_pulser
    import one_shot_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall_trig_in,
    input  logic             rise_trig_in,
    input  logic             clear_n_in,
    input  logic [CNT_W-1:0] width_in,
    output logic             pulse_out,
    output logic             pulse_n_out
);
    logic [NUM_IN-1:0] raw, lvl, prev;
    logic              busy, fire;

    // Pack the control inputs in package order.
    always_comb begin
        raw           = '0;
        raw[IN_FALL]  = fall_trig_in;
        raw[IN_RISE]  = rise_trig_in;
        raw[IN_CLEAR] = clear_n_in;
    end

    one_shot_sync #(.N(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(raw), .lvl(lvl), .prev(prev)
    );

    one_shot_qualify u_qual (
        .clk(clk), .rst_n(rst_n), .lvl(lvl), .prev(prev), .busy(busy), .fire(fire)
    );

    one_shot_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clear_lvl(lvl[IN_CLEAR]), .load(fire),
        .width(width_in), .busy(busy)
    );

    // Complementary outputs driven from the timer state.
    assign pulse_out   = busy;
    assign pulse_n_out = ~busy;

    // R6: outputs always complementary.
    assert_complement_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_out != pulse_n_out);

    // R8: a pulse only begins the cycle after an accepted trigger.
    assert_rise_after_fire_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_out) |-> $past(fire));

    // R7: a zero width accepted yields no pulse.
    assert_zero_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && width_in == '0) |=> !pulse_out);
endmodule

// File: tb/one_shot_pulser_bench.sv
module one_shot_pulser_bench;
    localparam int CNT_W = 8;
    localparam int NV    = 8;
    // {fall0, rise0, fall1, rise1, width[7:0], expected_len[3:0]}
    localparam logic [15:0] VEC [NV] = '{
        {4'b1101, 8'd5,  4'd5},  // R1 fall with rise high
        {4'b1000, 8'd5,  4'd0},  // R1 fall with rise low
        {4'b0001, 8'd7,  4'd7},  // R2 rise with fall low
        {4'b1011, 8'd4,  4'd0},  // R2 rise with fall high
        {4'b1001, 8'd3,  4'd3},  // R1/R2 both edges together
        {4'b1101, 8'd0,  4'd0},  // R7 width zero
        {4'b0001, 8'd1,  4'd1},  // R7 width one
        {4'b0111, 8'd6,  4'd0}   // R1 wrong direction on fall input
    };
    localparam int VREQ [NV] = '{1, 1, 2, 2, 1, 7, 7, 1};

    logic clk = 0, rst_n = 0;
    logic fall_t = 0, rise_t = 1, clr_n = 1;
    logic [CNT_W-1:0] width = 8'd5;
    logic pulse, pulse_n;
    int total = 0, fails = 0;
    int hi, first, idx, mism;

    always #10 clk = ~clk;

    one_shot_pulser #(.CNT_W(CNT_W)) u_one_shot_pulser (
        .clk(clk), .rst_n(rst_n), .fall_trig_in(fall_t), .rise_trig_in(rise_t),
        .clear_n_in(clr_n), .width_in(width), .pulse_out(pulse), .pulse_n_out(pulse_n)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic start_meas();
        hi = 0; first = -1; idx = 0; mism = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            idx++;
            if (pulse) begin
                hi++;
                if (first < 0) first = idx;
            end
            if (pulse_n == pulse) mism++;
        end
    endtask

    initial begin
        #(20 * 200000);
        fails++; total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        // Reset with fall low and rise high (clear-release levels held).
        fall_t = 0; rise_t = 1; clr_n = 1;
        repeat (4) @(negedge clk);
        check("R9 reset pulse low", int'(pulse), 0);
        check("R6 reset pulse_n high", int'(pulse_n), 1);
        rst_n = 1;
        start_meas(); ticks(12);
        check("R9 no false edge after reset", hi, 0);

        // Vector table.
        for (int v = 0; v < NV; v++) begin
            fall_t = VEC[v][15]; rise_t = VEC[v][14]; clr_n = 1;
            width = VEC[v][11:4];
            ticks(30);
            start_meas();
            fall_t = VEC[v][13]; rise_t = VEC[v][12];
            ticks(30);
            check($sformatf("R%0d vector %0d length", VREQ[v], v), hi, int'(VEC[v][3:0]));
            if (VEC[v][3:0] != 0)
                check($sformatf("R8 vector %0d first high tick", v), first, 3);
            check($sformatf("R6 vector %0d complement", v), mism, 0);
        end

        // R5: fresh edge detected on the last pulse cycle is ignored.
        fall_t = 1; rise_t = 1; width = 8'd10; ticks(30);
        start_meas(); fall_t = 0; ticks(4); fall_t = 1; ticks(6); fall_t = 0; ticks(30);
        check("R5 edge on final cycle ignored", hi, 10);

        // R5: same edge one cycle later starts a new pulse.
        fall_t = 1; ticks(30);
        start_meas(); fall_t = 0; ticks(4); fall_t = 1; ticks(7); fall_t = 0; ticks(30);
        check("R5 edge after timeout accepted", hi, 20);

        // R3: clear mid-pulse cuts it short.
        fall_t = 1; ticks(30);
        start_meas(); fall_t = 0; ticks(5); clr_n = 0; ticks(25);
        check("R3 clear truncates pulse", hi, 5);
        check("R3 pulse_n high in clear", int'(pulse_n), 1);
        fall_t = 1; ticks(5); fall_t = 0; ticks(10);
        check("R3 trigger ignored while cleared", hi, 5);

        // R4: clear release with fall low, rise high fires.
        width = 8'd6;
        start_meas(); clr_n = 1; ticks(30);
        check("R4 clear release fires length", hi, 6);
        check("R4 clear release first high tick", first, 3);

        // R4: clear release with fall high does not fire.
        clr_n = 0; ticks(5); fall_t = 1; ticks(10);
        start_meas(); clr_n = 1; ticks(30);
        check("R4 clear release inhibited", hi, 0);

        // R7: width changed after acceptance has no effect.
        width = 8'd5; ticks(10);
        start_meas(); fall_t = 0; ticks(4); width = 8'd12; ticks(30);
        check("R7 width sampled at accept", hi, 5);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule